// File: doc/BRIEF.md
# Four-Channel Programmable Down-Counter/Timer

This block holds four independent 8-bit down-counters that share one byte-wide write/read port. Each channel is selected by a 2-bit address. A channel runs in one of two ways. As a timer it counts system clocks through a prescaler that divides by 16 or by 256. As a counter it counts one chosen edge polarity of its own external input, which is synchronized inside the block. Each channel reloads from a programmed time constant. Each time it reaches zero it gives a one-cycle pulse on its zero output, and it can also raise an interrupt.

Software sends every byte to the same port, and the block sorts each byte by its low bit and by whether a time constant is awaited. A byte with the low bit set is a control word. A byte that follows a control word asking for a constant is that constant. Any other byte with the low bit clear sets the shared interrupt vector base. When channels have interrupts pending, the block shows one request line and a vector. The vector carries the base, the number of the lowest-numbered pending channel, and a zero low bit. An acknowledge pulse clears the request of the channel that is shown.

Top module: `quad_timer`

## Requirements
- R1: Writes are decoded in this order. If the addressed channel awaits a time constant, the byte becomes its constant, whatever its bit 0. Otherwise a byte with bit 0 = 1 is that channel's control word. Otherwise bits 7:3 of the byte become the shared vector base.
- R2: The control word fields are: bit 7 interrupt enable, bit 6 counter mode (1) or timer mode (0), bit 5 prescale 256 (1) or 16 (0), bit 4 rising (1) or falling (0) external edge, bit 3 wait for trigger, bit 2 time constant follows, bit 1 channel reset. In timer mode without a trigger, a stopped channel starts on the clock edge that takes its time constant N. Its first zero pulse appears N x prescale clocks later.
- R3: A time constant of 0 behaves as 256. With prescale 16, the first zero pulse therefore comes 4096 clocks after the write.
- R4: At zero, the count reloads with the time constant and the zero output is high for exactly one cycle. Later zero pulses repeat with the same period.
- R5: A control word with bit 1 set stops the channel and clears its pending interrupt. The count then holds and no zero pulse appears. The channel restarts only when a new time constant is written.
- R6: A control word with bit 1 clear leaves a running count undisturbed. The zero pulse period goes on unchanged.
- R7: In counter mode the count drops by one on each edge of the synchronized external input that bit 4 selects. Edges of the other polarity are ignored.
- R8: In timer mode with bit 3 set, the channel holds its count after the constant is written. It starts at the third clock edge after the selected external edge appears at the input. Its first zero pulse follows N x prescale clocks after that start.
- R9: A channel with bit 7 set becomes pending at its zero event. One cycle after the zero pulse, irq is high and int_vector equals {base[7:3], channel[1:0], 0}. An int_ack pulse clears the shown channel, and irq is low two clock edges after the ack.
- R10: rd_data gives the addressed channel's count one cycle after rd_en. After rst, every count reads 0, and irq, zero_out and int_vector are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one byte |
| rd_en | input | 1 | Read strobe; rd_data updates on the next edge |
| addr | input | 2 | Channel select |
| wr_data | input | 8 | Written byte |
| rd_data | output | 8 | Current count of the addressed channel (registered) |
| ext_in | input | 4 | Per-channel external count/trigger inputs (asynchronous) |
| zero_out | output | 4 | One-cycle pulse per channel at its zero event |
| int_ack | input | 1 | Clears the pending request that int_vector shows |
| irq | output | 1 | High while any channel has an interrupt pending |
| int_vector | output | 8 | Vector base, pending channel number and a zero low bit |

## Verification
A wrong decoding state shows within one period. If a constant is mistaken for a control word or a vector, the channel never starts or the vector base becomes wrong. That is visible at the first expected zero pulse or at the first interrupt. An error in the prescaler or the reload shifts the zero pulse timing by whole cycles. The bench measures that spacing exactly on the first and the second period. Stuck run or wait flags show as a count read back that moves when it should hold, or that holds when it should move, within a few hundred cycles.

// File: rtl/qt_pkg.sv
package qt_pkg;
  // Stored part of a channel control word (byte bits 7:3).
  typedef struct packed {
    logic ie;        // interrupt enable
    logic cnt_mode;  // 1: count external edges, 0: timer
    logic ps_big;    // 1: divide by the large prescale
    logic rising;    // 1: rising edge, 0: falling edge
    logic trig;      // timer waits for external edge
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/qt_edge.sv
module qt_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], din};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~prev_q;
  assign fall = ~sync_q[STAGES-1] & prev_q;
endmodule

// File: rtl/qt_prescaler.sv
module qt_prescaler #(
  parameter int PS_LO = 16,
  parameter int PS_HI = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic en,
  input  logic sel_hi,
  output logic tick
);
  localparam int PW = $clog2(PS_HI);
  localparam logic [PW-1:0] LO_MAX = PW'(PS_LO - 1);
  localparam logic [PW-1:0] HI_MAX = PW'(PS_HI - 1);

  logic [PW-1:0] ps_q;
  logic [PW-1:0] lim;

  assign lim  = sel_hi ? HI_MAX : LO_MAX;
  assign tick = en && (ps_q >= lim);

  always_ff @(posedge clk) begin
    if (rst || clear) ps_q <= '0;
    else if (en) ps_q <= (ps_q >= lim) ? '0 : ps_q + 1'b1;
  end
endmodule

// File: rtl/qt_channel.sv
module qt_channel
  import qt_pkg::*;
#(
  parameter int DW     = 8,
  parameter int PS_LO  = 16,
  parameter int PS_HI  = 256,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_i,
  input  logic [DW-1:0] data_i,
  input  logic          ext_i,
  input  logic          clr_i,
  output logic          tc_wait_o,
  output logic [DW-1:0] cnt_o,
  output logic          zero_o,
  output logic          pend_o
);
  ctrl_t         ctrl_q;
  logic [DW-1:0] tc_q, cnt_q;
  logic          run_q, trig_wait_q, tcp_q, zero_q, pend_q;
  logic          rise, fall, edge_hit, ps_tick, dec, zero_ev;

  qt_edge #(.STAGES(STAGES)) u_edge (
    .clk(clk), .rst(rst), .din(ext_i), .rise(rise), .fall(fall)
  );

  qt_prescaler #(.PS_LO(PS_LO), .PS_HI(PS_HI)) u_ps (
    .clk(clk), .rst(rst), .clear(!run_q),
    .en(run_q && !ctrl_q.cnt_mode), .sel_hi(ctrl_q.ps_big), .tick(ps_tick)
  );

  assign edge_hit = ctrl_q.rising ? rise : fall;
  assign dec      = run_q && (ctrl_q.cnt_mode ? edge_hit : ps_tick);
  assign zero_ev  = dec && (cnt_q == DW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q      <= '0;
      tc_q        <= '0;
      cnt_q       <= '0;
      run_q       <= 1'b0;
      trig_wait_q <= 1'b0;
      tcp_q       <= 1'b0;
      zero_q      <= 1'b0;
      pend_q      <= 1'b0;
    end else begin
      zero_q <= zero_ev;
      if (dec) cnt_q <= zero_ev ? tc_q : cnt_q - 1'b1;
      if (zero_ev && ctrl_q.ie) pend_q <= 1'b1;
      if (clr_i) pend_q <= 1'b0;
      if (trig_wait_q && edge_hit) begin
        trig_wait_q <= 1'b0;
        run_q       <= 1'b1;
      end
      if (wr_i) begin
        if (tcp_q) begin
          tc_q  <= data_i;
          tcp_q <= 1'b0;
          if (!run_q) begin
            cnt_q <= data_i;
            if (!ctrl_q.cnt_mode && ctrl_q.trig) trig_wait_q <= 1'b1;
            else run_q <= 1'b1;
          end
        end else if (data_i[0]) begin
          ctrl_q <= ctrl_t'(data_i[DW-1:DW-CTRL_W]);
          tcp_q  <= data_i[2];
          if (data_i[1]) begin
            run_q       <= 1'b0;
            trig_wait_q <= 1'b0;
            pend_q      <= 1'b0;
          end
        end
      end
    end
  end

  assign tc_wait_o = tcp_q;
  assign cnt_o     = cnt_q;
  assign zero_o    = zero_q;
  assign pend_o    = pend_q;

  // R4
  zero_single_chk: assert property (@(posedge clk) disable iff (rst)
    zero_q |=> !zero_q);

  // R4
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(zero_q) |-> cnt_q == $past(tc_q));

  // R5
  stopped_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !(wr_i && tcp_q)) |=> $stable(cnt_q));

  // R9
  pend_enable_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pend_q) |-> $past(ctrl_q.ie));
endmodule

// File: rtl/qt_irq_sel.sv
module qt_irq_sel #(
  parameter int NCH = 4,
  localparam int CW = $clog2(NCH)
) (
  input  logic [NCH-1:0] pend,
  output logic           any,
  output logic [CW-1:0]  idx
);
  always_comb begin
    any = |pend;
    idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (pend[i]) idx = CW'(i);
    end
  end
endmodule

// File: rtl/quad_timer.sv
module quad_timer #(
  parameter int NCH    = 4,
  parameter int DW     = 8,
  parameter int PS_LO  = 16,
  parameter int PS_HI  = 256,
  parameter int STAGES = 2,
  localparam int AW    = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wr_data,
  output logic [DW-1:0]  rd_data,
  input  logic [NCH-1:0] ext_in,
  output logic [NCH-1:0] zero_out,
  input  logic           int_ack,
  output logic           irq,
  output logic [DW-1:0]  int_vector
);
  localparam int BW = DW - AW - 1;  // vector base width

  logic [NCH-1:0] tcw, pend, clr, zero_w;
  logic [DW-1:0]  cnt_w [NCH];
  logic [BW-1:0]  vbase_q;
  logic [DW-1:0]  rd_q, vec_q;
  logic           irq_q, any;
  logic [AW-1:0]  sel_idx;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    qt_channel #(.DW(DW), .PS_LO(PS_LO), .PS_HI(PS_HI), .STAGES(STAGES)) u_ch (
      .clk(clk), .rst(rst),
      .wr_i(wr_en && (addr == AW'(g))), .data_i(wr_data),
      .ext_i(ext_in[g]), .clr_i(clr[g]),
      .tc_wait_o(tcw[g]), .cnt_o(cnt_w[g]),
      .zero_o(zero_w[g]), .pend_o(pend[g])
    );
  end

  qt_irq_sel #(.NCH(NCH)) u_sel (.pend(pend), .any(any), .idx(sel_idx));

  always_comb begin
    clr = '0;
    if (int_ack && any) clr[sel_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vbase_q <= '0;
      rd_q    <= '0;
      vec_q   <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (wr_en && !wr_data[0] && !tcw[addr]) vbase_q <= wr_data[DW-1:DW-BW];
      if (rd_en) rd_q <= cnt_w[addr];
      irq_q <= any;
      vec_q <= {vbase_q, sel_idx, 1'b0};
    end
  end

  assign rd_data    = rd_q;
  assign zero_out   = zero_w;
  assign irq        = irq_q;
  assign int_vector = vec_q;
endmodule

// File: tb/quad_timer_test.sv
module quad_timer_test;
  localparam int CLK_NS = 10;
  // {channel, control, time constant, expected clocks to first zero}
  localparam logic [39:0] TBL [0:3] = '{
    40'h00_07_03_0030,   // timer /16, N=3 -> 48
    40'h01_07_01_0010,   // timer /16, N=1 -> 16
    40'h02_27_01_0100,   // timer /256, N=1 -> 256
    40'h03_07_00_1000    // timer /16, N=0 (256) -> 4096
  };

  logic       clk = 0, rst = 1, wr_en = 0, rd_en = 0, int_ack = 0;
  logic [1:0] addr = 0;
  logic [7:0] wr_data = 0, rd_data, int_vector;
  logic [3:0] ext_in = 0, zero_out;
  logic       irq;
  int checks = 0, errors = 0;
  int zc [4] = '{0, 0, 0, 0};

  quad_timer uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .ext_in(ext_in),
    .zero_out(zero_out), .int_ack(int_ack), .irq(irq), .int_vector(int_vector)
  );

  always #(CLK_NS / 2) clk = ~clk;

  // Counts zero pulses using pre-edge values.
  always @(posedge clk) begin
    for (int i = 0; i < 4; i++) if (zero_out[i]) zc[i]++;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int ch, input logic [7:0] d);
    wr_en = 1; addr = 2'(ch); wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input int ch, output logic [7:0] v);
    rd_en = 1; addr = 2'(ch);
    @(negedge clk);
    rd_en = 0;
    v = rd_data;
  endtask

  task automatic wait_zero(input int ch, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!zero_out[ch] && n < 20000);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] v, v2;
    int n, snap;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R10 reset state
    check(zero_out == 0 && irq == 0 && int_vector == 0, "R10 reset outputs",
          {zero_out, irq, int_vector}, 0);
    for (int c = 0; c < 4; c++) begin
      rd(c, v);
      check(v == 0, "R10 reset count", v, 0);
    end

    // Table walk: R1 (constants with bit0=1 still taken as constants), R2, R3, R4
    for (int e = 0; e < 4; e++) begin
      int ch, exp;
      logic [7:0] ctl, tc;
      ch = int'(TBL[e][39:32]); ctl = TBL[e][31:24];
      tc = TBL[e][23:16];       exp = int'(TBL[e][15:0]);
      wr(ch, ctl);
      wr(ch, tc);
      wait_zero(ch, n);
      check(n == exp, (tc == 0) ? "R3 zero constant period" : "R2 R1 first period", n, exp);
      rd(ch, v);
      check(v == tc, "R4 reload value", v, tc);
      wait_zero(ch, n);
      check(n == exp - 1, "R4 second period", n, exp - 1);
    end

    // R5 channel reset stops channel 1
    wr(1, 8'h03);
    snap = zc[1];
    rd(1, v);
    repeat (100) @(negedge clk);
    rd(1, v2);
    check(v == v2, "R5 count holds", v2, v);
    check(zc[1] == snap, "R5 no zero pulse", zc[1] - snap, 0);
    wr(1, 8'h05);
    wr(1, 8'h01);
    wait_zero(1, n);
    check(n == 16, "R5 restart on new constant", n, 16);

    // R6 control word without reset keeps channel 0 counting
    wait_zero(0, n);
    repeat (9) @(negedge clk);
    wr(0, 8'h01);
    wait_zero(0, n);
    check(n == 38, "R6 period undisturbed", n, 38);

    // R1 vector load, R9 interrupt on channel 2
    wr(0, 8'hA6);
    wr(2, 8'h87);
    wr(2, 8'h02);
    check(irq == 0, "R9 no early irq", irq, 0);
    wait_zero(2, n);
    check(n == 32, "R2 channel 2 period", n, 32);
    @(negedge clk);
    check(irq == 1, "R9 irq raised", irq, 1);
    check(int_vector == 8'hA4, "R9 R1 vector", int_vector, 8'hA4);
    int_ack = 1;
    @(negedge clk);
    int_ack = 0;
    @(negedge clk);
    check(irq == 0, "R9 ack clears irq", irq, 0);
    wr(2, 8'h03);

    // R7 counter mode, rising edges on channel 3
    wr(3, 8'h57);
    wr(3, 8'h03);
    snap = zc[3];
    for (int p = 0; p < 2; p++) begin
      ext_in[3] = 1; repeat (4) @(negedge clk);
      ext_in[3] = 0; repeat (4) @(negedge clk);
    end
    rd(3, v);
    check(v == 1, "R7 two rising edges", v, 1);
    ext_in[3] = 1; repeat (4) @(negedge clk);
    ext_in[3] = 0; repeat (4) @(negedge clk);
    rd(3, v);
    check(v == 3, "R7 reload at zero", v, 3);
    check(zc[3] == snap + 1, "R7 zero pulse", zc[3] - snap, 1);
    // R7 falling edge select
    wr(3, 8'h47);
    wr(3, 8'h05);
    ext_in[3] = 1; repeat (4) @(negedge clk);
    rd(3, v);
    check(v == 5, "R7 rising ignored", v, 5);
    ext_in[3] = 0; repeat (4) @(negedge clk);
    rd(3, v);
    check(v == 4, "R7 falling counted", v, 4);

    // R8 trigger start on channel 1, rising edge
    wr(1, 8'h1F);
    wr(1, 8'h02);
    snap = zc[1];
    repeat (100) @(negedge clk);
    check(zc[1] == snap, "R8 waits for trigger", zc[1] - snap, 0);
    rd(1, v);
    check(v == 2, "R8 count held", v, 2);
    ext_in[1] = 1;
    wait_zero(1, n);
    check(n == 35, "R8 trigger latency", n, 35);

    finish_run();
  end
endmodule